// File: doc/BRIEF.md
# VLAN Tag Editor

This block sits on the egress path of one switch port. It is a byte-wide frame stream with valid, start-of-frame, end-of-frame and ready signals. For each frame it either adds an 802.1Q tag, removes one, or passes the frame through unchanged. The choice depends on two per-port control bits. It looks for the tag type value 0x8100 in the two bytes that follow the destination and source addresses, at frame byte offsets 12 and 13.

The source port of a frame is given on `in_port` alongside the first byte of the frame. That index selects the port's add-tag bit, its remove-tag bit and its 16-bit tag control value. There is one value per port, held as a high byte and a low byte. The frame check sequence is not recomputed and short frames are not padded. Those jobs, and arbitration between ports, belong to neighbouring blocks.

Top module: `vlan_tag_editor`

## Requirements
- R1: An untagged frame from a port whose add bit is set leaves with 0x81, 0x00 and the port's tag value inserted after byte 11. The tag value goes high byte (bits 15:8) first, then the low byte. The original bytes 12 onward follow unchanged, so the frame grows by 4 bytes. A frame counts as untagged unless byte 12 is 0x81 and byte 13 is 0x00, so 0x81 followed by 0x01 still counts as untagged.
- R2: A tagged frame from a port whose remove bit is set leaves without bytes 12 to 15. Every other byte is kept in order, so the frame shrinks by 4 bytes.
- R3: A tagged frame from a port with only the add bit set leaves unchanged.
- R4: An untagged frame from a port with only the remove bit set leaves unchanged.
- R5: With both bits set on a port, tagged frames are stripped as in R2 and untagged frames are tagged as in R1.
- R6: Port p's tag value is `cfg_tag[p*16 +: 16]`, and its control bits are `cfg_add_en[p]` and `cfg_remove_en[p]`. The port is the value of `in_port` on the start-of-frame byte.
- R7: A frame whose `in_port` is NPORT or above leaves unchanged.
- R8: Short frames follow these rules:
  - A frame of fewer than 14 bytes is never edited.
  - A tagged frame of 16 bytes or fewer is not stripped and leaves unchanged.
  - An untagged 14-byte frame is still tagged and leaves as 18 bytes.
- R9: While `out_valid` is high and `out_ready` is low, the output beat (`out_data`, `out_sop`, `out_eop`) and `out_valid` hold until the next cycle.
- R10: Every output frame starts with exactly one `out_sop` beat and ends with exactly one `out_eop` beat. No byte is lost or duplicated under any pattern of input gaps and output stalls, including while inserted bytes drain.
- R11: During and right after reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Input beat is first byte of frame |
| in_eop | input | 1 | Input beat is last byte of frame |
| in_data | input | 8 | Input byte |
| in_port | input | PORT_W | Source port index, sampled with the first byte |
| in_ready | output | 1 | Block accepts an input beat this cycle |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output beat is first byte of frame |
| out_eop | output | 1 | Output beat is last byte of frame |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the output beat |
| cfg_add_en | input | NPORT | Per-port add-tag enable |
| cfg_remove_en | input | NPORT | Per-port remove-tag enable |
| cfg_tag | input | 16*NPORT | Per-port tag control values, port p at bits p*16+15 down to p*16 |

## Verification
The bench builds the block with NPORT=5 and PORT_W=3. This leaves indices 5 to 7 out of range and lets the out-of-range rule be driven directly. FIFO_DEPTH=2 makes the output buffer fill inside the six-byte emission that follows a tag decision. Random output stalls and input gaps therefore hit the controller while it is collecting, emitting and streaming the body.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

    localparam int unsigned BYTE_W     = 8;
    // bytes that precede the type field (two 6-byte addresses)
    localparam int unsigned ADDR_BYTES = 12;
    localparam int unsigned TAG_BYTES  = 4;
    // held bytes: type field plus tag, or tag plus original type field
    localparam int unsigned HOLD_N     = TAG_BYTES + 2;
    localparam logic [15:0] TPID       = 16'h8100;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [BYTE_W-1:0] data;
    } beat_t;

    typedef enum logic [1:0] {
        ST_HEAD,   // address bytes, passed through
        ST_GRAB,   // collecting type/tag bytes
        ST_EMIT,   // draining the hold buffer, input stalled
        ST_BODY    // remainder of frame, passed through
    } edit_state_e;

endpackage

// File: rtl/vtag_cfg_sel.sv
module vtag_cfg_sel #(
    parameter int unsigned NPORT  = 9,
    parameter int unsigned PORT_W = 4
) (
    input  logic [PORT_W-1:0]     port_i,
    input  logic [NPORT-1:0]      add_en_i,
    input  logic [NPORT-1:0]      remove_en_i,
    input  logic [NPORT*16-1:0]   tag_i,
    output logic                  add_o,
    output logic                  remove_o,
    output logic [15:0]           tci_o
);

    logic [NPORT-1:0] hit;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign hit[p] = (port_i == PORT_W'(p));
    end

    always_comb begin
        add_o    = |(hit & add_en_i);
        remove_o = |(hit & remove_en_i);
        tci_o    = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (hit[p]) begin
                tci_o = tag_i[p*16 +: 16];
            end
        end
    end

endmodule

// File: rtl/vtag_fifo.sv
module vtag_fifo
    import vtag_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  beat_t push_beat_i,
    output logic  full_o,
    input  logic  pop_i,
    output logic  valid_o,
    output beat_t head_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        beat_t [DEPTH-1:0] mem;
        logic  [PTR_W-1:0] wr;
        logic  [PTR_W-1:0] rd;
        logic  [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_push, do_pop;

    assign full_o  = (s_q.cnt == CNT_W'(DEPTH));
    assign valid_o = (s_q.cnt != '0);
    assign head_o  = s_q.mem[s_q.rd];

    always_comb begin
        s_d     = s_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && valid_o;
        if (do_push) begin
            s_d.mem[s_q.wr] = push_beat_i;
            s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + PTR_W'(1);
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + PTR_W'(1);
        end
        s_d.cnt = s_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/vtag_ctrl.sv
module vtag_ctrl
    import vtag_pkg::*;
#(
    parameter int unsigned PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic              in_sop_i,
    input  logic              in_eop_i,
    input  logic [BYTE_W-1:0] in_data_i,
    input  logic [PORT_W-1:0] in_port_i,
    output logic              in_ready_o,
    output logic [PORT_W-1:0] port_o,
    input  logic              add_en_i,
    input  logic              remove_en_i,
    input  logic [15:0]       tci_i,
    input  logic              fifo_full_i,
    output logic              push_o,
    output beat_t             push_beat_o
);

    localparam int unsigned IDX_W = $clog2(ADDR_BYTES);
    localparam int unsigned HW    = $clog2(HOLD_N + 1);

    typedef struct packed {
        edit_state_e                   st;
        logic [IDX_W-1:0]              idx;
        logic [PORT_W-1:0]             port;
        logic [HOLD_N-1:0][BYTE_W-1:0] hold;
        logic [HW-1:0]                 cnt;
        logic [HW-1:0]                 ptr;
        logic                          last;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic     tagged_now;
    logic     emit_last;

    assign port_o = s_q.port;

    always_comb begin
        s_d         = s_q;
        in_ready_o  = 1'b0;
        push_o      = 1'b0;
        push_beat_o = '0;
        tagged_now  = (s_q.hold[0] == TPID[15:8]) && (in_data_i == TPID[7:0]);
        emit_last   = (s_q.ptr == s_q.cnt - HW'(1));

        unique case (s_q.st)
            ST_HEAD: begin
                in_ready_o = !fifo_full_i;
                if (in_valid_i && !fifo_full_i) begin
                    push_o      = 1'b1;
                    push_beat_o = '{sop: in_sop_i, eop: in_eop_i, data: in_data_i};
                    if (in_sop_i) s_d.port = in_port_i;
                    if (in_eop_i) begin
                        s_d.idx = '0;
                    end else if (s_q.idx == IDX_W'(ADDR_BYTES - 1)) begin
                        s_d.idx = '0;
                        s_d.cnt = '0;
                        s_d.st  = ST_GRAB;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end

            ST_GRAB: begin
                in_ready_o = 1'b1;
                if (in_valid_i) begin
                    s_d.hold[s_q.cnt] = in_data_i;
                    s_d.cnt  = s_q.cnt + HW'(1);
                    s_d.last = in_eop_i;
                    s_d.ptr  = '0;
                    if (s_q.cnt == HW'(1) && !tagged_now && add_en_i) begin
                        // tag type, tag value, then the original type bytes
                        s_d.hold = {in_data_i, s_q.hold[0], tci_i[7:0], tci_i[15:8],
                                    TPID[7:0], TPID[15:8]};
                        s_d.cnt  = HW'(HOLD_N);
                        s_d.st   = ST_EMIT;
                    end else if (in_eop_i) begin
                        s_d.st = ST_EMIT;
                    end else if (s_q.cnt == HW'(1) && !(tagged_now && remove_en_i)) begin
                        s_d.st = ST_EMIT;
                    end else if (s_q.cnt == HW'(TAG_BYTES - 1)) begin
                        // full tag collected with frame continuing: drop it
                        s_d.cnt = '0;
                        s_d.st  = ST_BODY;
                    end
                end
            end

            ST_EMIT: begin
                if (!fifo_full_i) begin
                    push_o      = 1'b1;
                    push_beat_o = '{sop: 1'b0, eop: s_q.last && emit_last,
                                    data: s_q.hold[s_q.ptr]};
                    if (emit_last) begin
                        s_d.ptr = '0;
                        s_d.cnt = '0;
                        s_d.st  = s_q.last ? ST_HEAD : ST_BODY;
                    end else begin
                        s_d.ptr = s_q.ptr + HW'(1);
                    end
                end
            end

            ST_BODY: begin
                in_ready_o = !fifo_full_i;
                if (in_valid_i && !fifo_full_i) begin
                    push_o      = 1'b1;
                    push_beat_o = '{sop: in_sop_i, eop: in_eop_i, data: in_data_i};
                    if (in_eop_i) s_d.st = ST_HEAD;
                end
            end

            default: s_d.st = ST_HEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_HEAD, default: '0};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/vlan_tag_editor.sv
module vlan_tag_editor
    import vtag_pkg::*;
#(
    parameter int unsigned NPORT      = 9,
    parameter int unsigned PORT_W     = 4,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sop,
    input  logic                in_eop,
    input  logic [7:0]          in_data,
    input  logic [PORT_W-1:0]   in_port,
    output logic                in_ready,
    output logic                out_valid,
    output logic                out_sop,
    output logic                out_eop,
    output logic [7:0]          out_data,
    input  logic                out_ready,
    input  logic [NPORT-1:0]    cfg_add_en,
    input  logic [NPORT-1:0]    cfg_remove_en,
    input  logic [NPORT*16-1:0] cfg_tag
);

    logic [PORT_W-1:0] frame_port;
    logic              sel_add, sel_remove;
    logic [15:0]       sel_tci;
    logic              fifo_full, push;
    beat_t             push_beat, head;

    vtag_cfg_sel #(.NPORT(NPORT), .PORT_W(PORT_W)) i_cfg_sel (
        .port_i      (frame_port),
        .add_en_i    (cfg_add_en),
        .remove_en_i (cfg_remove_en),
        .tag_i       (cfg_tag),
        .add_o       (sel_add),
        .remove_o    (sel_remove),
        .tci_o       (sel_tci)
    );

    vtag_ctrl #(.PORT_W(PORT_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_sop_i    (in_sop),
        .in_eop_i    (in_eop),
        .in_data_i   (in_data),
        .in_port_i   (in_port),
        .in_ready_o  (in_ready),
        .port_o      (frame_port),
        .add_en_i    (sel_add),
        .remove_en_i (sel_remove),
        .tci_i       (sel_tci),
        .fifo_full_i (fifo_full),
        .push_o      (push),
        .push_beat_o (push_beat)
    );

    vtag_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_beat_i (push_beat),
        .full_o      (fifo_full),
        .pop_i       (out_ready),
        .valid_o     (out_valid),
        .head_o      (head)
    );

    assign out_sop  = head.sop;
    assign out_eop  = head.eop;
    assign out_data = head.data;

endmodule

// File: rtl/vtag_checker.sv
module vtag_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_sop,
    input logic       out_eop,
    input logic [7:0] out_data,
    input logic       in_ready
);

    logic in_frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
        end else if (out_valid && out_ready) begin
            in_frame_q <= (out_sop || in_frame_q) && !out_eop;
        end
    end

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sop) && $stable(out_eop)); // R9

    AST_SOP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> !in_frame_q); // R10

    AST_BODY_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sop |-> in_frame_q); // R10

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && in_ready); // R11

endmodule

bind vlan_tag_editor vtag_checker i_vtag_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data),
    .in_ready  (in_ready)
);

// File: tb/test_vlan_tag_editor.sv
module test_vlan_tag_editor;

    localparam int CLK_PERIOD = 10;
    localparam int NPORT      = 5;
    localparam int PORT_W     = 3;
    localparam int FIFO_DEPTH = 2;

    typedef logic [7:0] byte_q_t [$];

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]          in_data = '0;
    logic [PORT_W-1:0]   in_port = '0;
    logic                in_ready;
    logic                out_valid, out_sop, out_eop;
    logic [7:0]          out_data;
    logic                out_ready = 1'b1;
    logic [NPORT-1:0]    cfg_add_en = '0, cfg_remove_en = '0;
    logic [NPORT*16-1:0] cfg_tag = '0;

    int      total = 0, bad = 0;
    byte_q_t got;
    int      flag_err = 0, frames_done = 0, hold_err = 0;
    bit      stall_on = 0, gap_on = 0;
    bit      hold_prev = 0;
    logic [9:0] hold_beat = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlan_tag_editor #(.NPORT(NPORT), .PORT_W(PORT_W), .FIFO_DEPTH(FIFO_DEPTH)) i_vlan_tag_editor (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_port(in_port), .in_ready(in_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
        .out_ready(out_ready),
        .cfg_add_en(cfg_add_en), .cfg_remove_en(cfg_remove_en), .cfg_tag(cfg_tag)
    );

    // output ready pattern, changed just after each rising edge
    initial forever begin
        @(posedge clk); #1;
        out_ready = stall_on ? ($urandom % 3 != 0) : 1'b1;
    end

    // monitor, sampling at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_prev && (!out_valid || {out_sop, out_eop, out_data} != hold_beat))
                hold_err++;
            hold_prev = out_valid && !out_ready;
            hold_beat = {out_sop, out_eop, out_data};
            if (out_valid && out_ready) begin
                if ((got.size() == 0) != out_sop) flag_err++;
                got.push_back(out_data);
                if (out_eop) frames_done++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung (actual=timeout expected=completion)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [15:0] tag_of(int p);
        return 16'(16'h3A05 + p * 16'h0117);
    endfunction

    // kind 0: untagged (08 00), 1: tagged, 2: untagged starting with 81 01
    function automatic byte_q_t mk_frame(int len, int kind, logic [15:0] tci, int seed);
        byte_q_t q;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(seed * 31 + i * 7 + 3);
            if (i == 12) b = (kind == 0) ? 8'h08 : 8'h81;
            if (i == 13) b = (kind == 2) ? 8'h01 : 8'h00;
            if (i == 14 && kind == 1) b = tci[15:8];
            if (i == 15 && kind == 1) b = tci[7:0];
            q.push_back(b);
        end
        return q;
    endfunction

    function automatic byte_q_t with_tag(byte_q_t f, logic [15:0] tci);
        byte_q_t q;
        for (int i = 0; i < f.size(); i++) begin
            if (i == 12) begin
                q.push_back(8'h81); q.push_back(8'h00);
                q.push_back(tci[15:8]); q.push_back(tci[7:0]);
            end
            q.push_back(f[i]);
        end
        return q;
    endfunction

    function automatic byte_q_t without_tag(byte_q_t f);
        byte_q_t q;
        for (int i = 0; i < f.size(); i++)
            if (i < 12 || i > 15) q.push_back(f[i]);
        return q;
    endfunction

    task automatic fail_line(string req, string what, int act, int exp);
        bad++;
        $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic send(int port, byte_q_t d);
        for (int i = 0; i < d.size(); i++) begin
            bit acc;
            if (gap_on && ($urandom % 4 == 0)) begin
                in_valid = 1'b0; @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == d.size() - 1);
            in_data  = d[i];
            in_port  = PORT_W'(port);
            do begin
                @(negedge clk); acc = in_ready;
                @(posedge clk); #1;
            end while (!acc);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic run_case(string req, int port, byte_q_t din, byte_q_t exp);
        got.delete(); flag_err = 0; frames_done = 0;
        send(port, din);
        for (int k = 0; k < 400 && frames_done == 0; k++) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
        total++;
        if (frames_done != 1) fail_line(req, "frames", frames_done, 1);
        else if (got.size() != exp.size()) fail_line(req, "length", got.size(), exp.size());
        else if (flag_err != 0) fail_line(req, "sop/eop errors", flag_err, 0);
        else begin
            for (int i = 0; i < exp.size(); i++) begin
                if (got[i] != exp[i]) begin
                    fail_line(req, $sformatf("byte %0d", i), got[i], exp[i]);
                    break;
                end
            end
        end
    endtask

    task automatic set_cfg(logic [NPORT-1:0] add, logic [NPORT-1:0] rem);
        cfg_add_en = add; cfg_remove_en = rem;
        for (int p = 0; p < NPORT; p++) cfg_tag[p*16 +: 16] = tag_of(p);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        total++; if (out_valid !== 1'b0) fail_line("R11", "out_valid after reset", out_valid, 0);
        total++; if (in_ready !== 1'b1) fail_line("R11", "in_ready after reset", in_ready, 1);
        @(posedge clk); #1;
    endtask

    task automatic t_insert;  // R1
        byte_q_t f;
        set_cfg(5'b00010, 5'b00000);
        f = mk_frame(20, 0, 16'h0, 1);
        run_case("R1", 1, f, with_tag(f, tag_of(1)));
        f = mk_frame(22, 2, 16'h0, 2);
        run_case("R1 (81 01 untagged)", 1, f, with_tag(f, tag_of(1)));
    endtask

    task automatic t_strip;  // R2
        byte_q_t f;
        set_cfg(5'b00000, 5'b00100);
        f = mk_frame(24, 1, 16'hE123, 3);
        run_case("R2", 2, f, without_tag(f));
    endtask

    task automatic t_add_only_tagged;  // R3
        byte_q_t f;
        set_cfg(5'b00010, 5'b00000);
        f = mk_frame(21, 1, 16'h0456, 4);
        run_case("R3", 1, f, f);
    endtask

    task automatic t_remove_only_untagged;  // R4
        byte_q_t f;
        set_cfg(5'b00000, 5'b00100);
        f = mk_frame(19, 0, 16'h0, 5);
        run_case("R4", 2, f, f);
    endtask

    task automatic t_both;  // R5
        byte_q_t f;
        set_cfg(5'b01000, 5'b01000);
        f = mk_frame(25, 1, 16'h7FFE, 6);
        run_case("R5 tagged", 3, f, without_tag(f));
        f = mk_frame(25, 0, 16'h0, 7);
        run_case("R5 untagged", 3, f, with_tag(f, tag_of(3)));
    endtask

    task automatic t_ports;  // R6
        byte_q_t f;
        set_cfg(5'b11111, 5'b00000);
        for (int p = 0; p < NPORT; p++) begin
            f = mk_frame(18, 0, 16'h0, 10 + p);
            run_case($sformatf("R6 port %0d", p), p, f, with_tag(f, tag_of(p)));
        end
    endtask

    task automatic t_out_of_range;  // R7
        byte_q_t f;
        set_cfg(5'b11111, 5'b11111);
        f = mk_frame(20, 0, 16'h0, 20);
        run_case("R7 untagged port 6", 6, f, f);
        f = mk_frame(20, 1, 16'h0ABC, 21);
        run_case("R7 tagged port 5", 5, f, f);
    endtask

    task automatic t_short;  // R8
        byte_q_t f;
        set_cfg(5'b00010, 5'b00100);
        f = mk_frame(1, 0, 16'h0, 30);
        run_case("R8 len 1", 1, f, f);
        f = mk_frame(12, 0, 16'h0, 31);
        run_case("R8 len 12", 1, f, f);
        f = mk_frame(13, 0, 16'h0, 32);
        run_case("R8 len 13", 1, f, f);
        f = mk_frame(14, 0, 16'h0, 33);
        run_case("R8 len 14 tagged on", 1, f, with_tag(f, tag_of(1)));
        for (int n = 14; n <= 16; n++) begin
            f = mk_frame(n, 1, 16'h0321, 34 + n);
            run_case($sformatf("R8 tagged len %0d", n), 2, f, f);
        end
        f = mk_frame(17, 1, 16'h0321, 60);
        run_case("R8 tagged len 17 stripped", 2, f, without_tag(f));
    endtask

    task automatic t_stall;  // R9, R10
        byte_q_t f, e;
        set_cfg(5'b00111, 5'b01110);
        stall_on = 1; gap_on = 1; hold_err = 0;
        for (int i = 0; i < 20; i++) begin
            int p, kind, len;
            p    = i % NPORT;
            kind = (i / NPORT) % 2;
            len  = 14 + (i * 3) % 15;
            f = mk_frame(len, kind, 16'h1234 + 16'(i), 70 + i);
            if (kind == 1 && cfg_remove_en[p] && len >= 17) e = without_tag(f);
            else if (kind == 0 && cfg_add_en[p]) e = with_tag(f, tag_of(p));
            else e = f;
            run_case($sformatf("R10 stall frame %0d", i), p, f, e);
        end
        stall_on = 0; gap_on = 0;
        repeat (3) @(posedge clk); #1;
        total++; if (hold_err != 0) fail_line("R9", "held beat changed", hold_err, 0);
    endtask

    initial begin
        t_reset();
        t_insert();
        t_strip();
        t_add_only_tagged();
        t_remove_only_untagged();
        t_both();
        t_ports();
        t_out_of_range();
        t_short();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule